// File: doc/BRIEF.md
# GPIO Edge and Level Event Controller

This block watches a set of GPIO inputs arranged in groups of up to eight pins. Each pin has its own trigger setting, and events are caught from a level or from an edge on the synchronised input. An event sets a sticky pending bit. Software reads the pending bits and acknowledges them by writing ones.

A per-pin mask decides whether a pending bit reaches the output. Consecutive groups are gathered into banks. Each bank drives one interrupt line, which is the OR of all unmasked pending bits in its groups.

Three register arrays are reached over a simple single-cycle register bus: trigger configuration, mask and pending. Each array holds one 32-bit word per group at a fixed byte offset. Reads are combinational. Writes take effect on the clock edge at which `busWr` is high.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: While reset is asserted, every configuration word reads 0, every mask word reads all ones in its low PINS bits, every pending word reads 0 and every bank line is low.
- R2: The word for group g sits at byte address 0x700+4g (configuration), 0x900+4g (mask) and 0xA00+4g (pending). An access is ignored, and a read returns 0, when the address is not word aligned, falls outside these arrays, or names a group index of NUM_GROUPS or above.
- R3: Pin n of a group takes its trigger code from configuration bits [4n+2:4n]. Code 0 is level low and code 1 is level high. In a level mode the pending bit is set on every cycle the level is active, so it comes back after a clear while the level persists.
- R4: Code 2 sets pending on a falling edge, code 3 on a rising edge and code 4 on either edge. A steady input sets nothing in these modes.
- R5: Codes 5, 6 and 7 never set the pending bit.
- R6: Writing a 1 to a pending bit clears it. Writing a 0 leaves that bit unchanged.
- R7: If an event and a write-1 clear reach the same pending bit in the same cycle, the bit stays set.
- R8: Bank b line is high exactly when some group g with floor(g/GROUPS_PER_BANK)=b has a pending bit whose mask bit is 0. A mask bit of 1 blocks that pin.
- R9: A pending bit is first visible on the third rising clock edge after the input changes, because of the two-flop synchroniser and the pending register.
- R10: A write to the pending array never sets a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| gpioIn | input | NUM_GROUPS*PINS | Asynchronous pin inputs. Group g pin n is bit g*PINS+n |
| busAddr | input | 12 | Byte address of the register access |
| busWr | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| irqBank | output | NUM_BANKS | One combined interrupt line per bank |

## Verification
The assertions check the pending bits only from the second cycle after reset. The bus decode check assumes that `busAddr` is driven to a known value on every cycle. The bench therefore holds the address at a valid value and changes bus signals and pin levels only on the falling edge. It observes edge-mode events from a known start level, with pending cleared and the pin set to the disabled code beforehand, so no stray edge or level sets a bit during the setup.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_CFG, ACC_MASK, ACC_PEND} acc_e;

  typedef struct packed {
    logic       wr;
    acc_e       kind;
    logic [7:0] grp;
  } strobe_t;

  localparam int unsigned CFG_BASE  = 32'h700;
  localparam int unsigned MASK_BASE = 32'h900;
  localparam int unsigned PEND_BASE = 32'hA00;

  localparam logic [2:0] TRIG_LOW  = 3'd0;
  localparam logic [2:0] TRIG_HIGH = 3'd1;
  localparam logic [2:0] TRIG_FALL = 3'd2;
  localparam logic [2:0] TRIG_RISE = 3'd3;
  localparam logic [2:0] TRIG_BOTH = 3'd4;
endpackage

// File: rtl/gpio_evt_decode.sv
module gpio_evt_decode
  import gpio_evt_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output strobe_t           stb
);
  localparam int unsigned SPAN = NUM_GROUPS * 4;

  int unsigned addrU;

  always_comb begin
    addrU    = 32'(busAddr);
    stb      = '0;
    stb.kind = ACC_NONE;
    if (busAddr[1:0] == 2'b00) begin
      if (addrU >= CFG_BASE && addrU < CFG_BASE + SPAN) begin
        stb.kind = ACC_CFG;
        stb.grp  = 8'((addrU - CFG_BASE) >> 2);
      end else if (addrU >= MASK_BASE && addrU < MASK_BASE + SPAN) begin
        stb.kind = ACC_MASK;
        stb.grp  = 8'((addrU - MASK_BASE) >> 2);
      end else if (addrU >= PEND_BASE && addrU < PEND_BASE + SPAN) begin
        stb.kind = ACC_PEND;
        stb.grp  = 8'((addrU - PEND_BASE) >> 2);
      end
    end
    stb.wr = busWr && (stb.kind != ACC_NONE);
  end

  // R2: any decoded access names an existing group
  a_r2_group_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind != ACC_NONE) |-> (32'(stb.grp) < NUM_GROUPS));
endmodule

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int PINS       = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_GROUPS*PINS-1:0]      gpioIn,
  input  strobe_t                         stb,
  input  logic [31:0]                     wdata,
  output logic [31:0]                     rdata,
  output logic [NUM_GROUPS-1:0][PINS-1:0] pendQ,
  output logic [NUM_GROUPS-1:0][PINS-1:0] maskQ
);
  localparam int CFG_W = PINS * 4;

  logic [NUM_GROUPS-1:0][PINS-1:0]  syncA, syncB, prevB, evt, clr;
  logic [NUM_GROUPS-1:0][CFG_W-1:0] cfgQ;
  logic                             armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
      armed <= 1'b0;
    end else begin
      syncA <= gpioIn;
      syncB <= syncA;
      prevB <= syncB;
      armed <= 1'b1;
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int n = 0; n < PINS; n++) begin
        case (cfgQ[g][4*n +: 3])
          TRIG_LOW:  evt[g][n] = ~syncB[g][n];
          TRIG_HIGH: evt[g][n] = syncB[g][n];
          TRIG_FALL: evt[g][n] = ~syncB[g][n] & prevB[g][n];
          TRIG_RISE: evt[g][n] = syncB[g][n] & ~prevB[g][n];
          TRIG_BOTH: evt[g][n] = syncB[g][n] ^ prevB[g][n];
          default:   evt[g][n] = 1'b0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    logic hit;
    assign hit    = stb.wr && (stb.grp == 8'(g));
    assign clr[g] = (hit && stb.kind == ACC_PEND) ? wdata[PINS-1:0] : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[g]  <= '0;
        maskQ[g] <= '1;
        pendQ[g] <= '0;
      end else begin
        if (hit && stb.kind == ACC_CFG)  cfgQ[g]  <= wdata[CFG_W-1:0];
        if (hit && stb.kind == ACC_MASK) maskQ[g] <= wdata[PINS-1:0];
        pendQ[g] <= (pendQ[g] & ~clr[g]) | evt[g];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (stb.grp == 8'(g)) begin
        case (stb.kind)
          ACC_CFG:  rdata = 32'(cfgQ[g]);
          ACC_MASK: rdata = 32'(maskQ[g]);
          ACC_PEND: rdata = 32'(pendQ[g]);
          default:  rdata = '0;
        endcase
      end
    end
  end

  // R7: an event in a cycle always leaves its pending bit set
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((pendQ & $past(evt)) == $past(evt)));
  // R10: a bit only rises when an event was present
  a_r10_no_set_without_event: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((pendQ & ~$past(pendQ) & ~$past(evt)) == '0));
  // R6: a cleared bit without a competing event reads zero afterwards
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((pendQ & $past(clr) & ~$past(evt)) == '0));
endmodule

// File: rtl/gpio_evt_merge.sv
module gpio_evt_merge #(
  parameter int NUM_GROUPS      = 4,
  parameter int PINS            = 8,
  parameter int GROUPS_PER_BANK = 2,
  localparam int NUM_BANKS      = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_GROUPS-1:0][PINS-1:0] pendQ,
  input  logic [NUM_GROUPS-1:0][PINS-1:0] maskQ,
  output logic [NUM_BANKS-1:0]            irqBank
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    always_comb begin
      irqBank[b] = 1'b0;
      for (int k = 0; k < GROUPS_PER_BANK; k++) begin
        if (b * GROUPS_PER_BANK + k < NUM_GROUPS)
          irqBank[b] = irqBank[b] | (|(pendQ[b*GROUPS_PER_BANK+k] & ~maskQ[b*GROUPS_PER_BANK+k]));
      end
    end
  end

  // R8: with every pin masked no bank line can be raised
  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> (irqBank == '0));
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_GROUPS      = 4,
  parameter int PINS            = 8,
  parameter int GROUPS_PER_BANK = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_GROUPS*PINS-1:0]     gpioIn,
  input  logic [11:0]                    busAddr,
  input  logic                           busWr,
  input  logic [31:0]                    busWdata,
  output logic [31:0]                    busRdata,
  output logic [(NUM_GROUPS+GROUPS_PER_BANK-1)/GROUPS_PER_BANK-1:0] irqBank
);
  strobe_t                         stb;
  logic [NUM_GROUPS-1:0][PINS-1:0] pendQ, maskQ;

  gpio_evt_decode #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(12)) uDec (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .stb(stb)
  );

  gpio_evt_datapath #(.NUM_GROUPS(NUM_GROUPS), .PINS(PINS)) uDp (
    .clk(clk), .rstN(rstN), .gpioIn(gpioIn), .stb(stb), .wdata(busWdata),
    .rdata(busRdata), .pendQ(pendQ), .maskQ(maskQ)
  );

  gpio_evt_merge #(.NUM_GROUPS(NUM_GROUPS), .PINS(PINS),
                   .GROUPS_PER_BANK(GROUPS_PER_BANK)) uMrg (
    .clk(clk), .rstN(rstN), .pendQ(pendQ), .maskQ(maskQ), .irqBank(irqBank)
  );
endmodule

// File: tb/sim_gpio_evt_ctrl.sv
module sim_gpio_evt_ctrl;
  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] gpioIn = '0;
  logic [11:0] busAddr = 12'h700;
  logic        busWr = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irqBank;
  int checks = 0, fails = 0;
  logic [31:0] rv;
  bit done = 0;

  gpio_evt_ctrl u0 (.clk(clk), .rstN(rstN), .gpioIn(gpioIn), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .irqBank(irqBank));

  always #5 clk = ~clk;

  // {code, start level, end level, expected pending}
  localparam logic [5:0] VEC [14] = '{
    {3'd3,1'b0,1'b1,1'b1}, {3'd3,1'b1,1'b0,1'b0}, {3'd2,1'b1,1'b0,1'b1},
    {3'd2,1'b0,1'b1,1'b0}, {3'd4,1'b0,1'b1,1'b1}, {3'd4,1'b1,1'b0,1'b1},
    {3'd4,1'b0,1'b0,1'b0}, {3'd1,1'b0,1'b1,1'b1}, {3'd1,1'b0,1'b0,1'b0},
    {3'd0,1'b1,1'b0,1'b1}, {3'd0,1'b1,1'b1,1'b0}, {3'd5,1'b0,1'b1,1'b0},
    {3'd6,1'b1,1'b0,1'b0}, {3'd7,1'b0,1'b1,1'b0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(posedge clk); #1 busWr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busWr = 0; #1 d = busRdata;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state, read while reset is held
    repeat (3) @(posedge clk);
    rd(12'h700, rv); chk("R1 cfg", rv, 32'h0);
    rd(12'h90C, rv); chk("R1 mask", rv, 32'hFF);
    rd(12'hA04, rv); chk("R1 pend", rv, 32'h0);
    chk("R1 irq", 32'(irqBank), 32'h0);
    @(negedge clk); rstN = 1;

    // R2 map
    wr(12'h70C, 32'h12345678); rd(12'h70C, rv); chk("R2 cfg g3", rv, 32'h12345678);
    wr(12'h904, 32'hFFFFFFA5); rd(12'h904, rv); chk("R2 mask g1", rv, 32'hA5);
    wr(12'h904, 32'hFF);
    wr(12'h901, 32'h0); rd(12'h900, rv); chk("R2 misaligned ignored", rv, 32'hFF);
    rd(12'h800, rv); chk("R2 unmapped", rv, 32'h0);
    rd(12'h710, rv); chk("R2 group out of range", rv, 32'h0);
    wr(12'h70C, 32'h0);

    // R3 R4 R5 vector table on group 1 pin 0
    foreach (VEC[i]) begin
      wr(12'h704, 32'h77777777);
      @(negedge clk); gpioIn[8] = VEC[i][2];
      repeat (4) @(posedge clk);
      wr(12'hA04, 32'h01);
      wr(12'h704, {28'h7777777, 1'b0, VEC[i][5:3]});
      @(negedge clk); gpioIn[8] = VEC[i][1];
      repeat (5) @(posedge clk);
      rd(12'hA04, rv);
      chk($sformatf("R3/R4/R5 vec %0d code %0d (R3 R4 R5)", i, VEC[i][5:3]),
          32'(rv[0]), 32'(VEC[i][0]));
    end

    // R9 latency on group 1 pin 1, rising edge
    wr(12'h704, 32'h77777737);
    wr(12'hA04, 32'h02);
    @(negedge clk); gpioIn[9] = 1;
    @(posedge clk); @(posedge clk);
    rd(12'hA04, rv); chk("R9 not yet after two edges", 32'(rv[1]), 32'h0);
    @(posedge clk);
    rd(12'hA04, rv); chk("R9 set on third edge", 32'(rv[1]), 32'h1);

    // R6 R10 on group 2 (latched by level low since reset, then disabled)
    wr(12'h708, 32'h77777777);
    rd(12'hA08, rv); chk("R6 pre", rv, 32'hFF);
    wr(12'hA08, 32'h0F); rd(12'hA08, rv); chk("R6 write one clears", rv, 32'hF0);
    wr(12'hA08, 32'h00); rd(12'hA08, rv); chk("R6 write zero keeps", rv, 32'hF0);
    wr(12'hA08, 32'h0F); rd(12'hA08, rv); chk("R10 write cannot set", rv, 32'hF0);

    // R7 group 0 level low active while clearing; R3 re-set after clear
    wr(12'hA00, 32'hFF); rd(12'hA00, rv); chk("R7 event beats clear", rv, 32'hFF);

    // R8 bank merge
    chk("R8 all masked", 32'(irqBank), 32'h0);
    wr(12'h908, 32'hEF); rd(12'hA00, rv); chk("R8 bank1 only", 32'(irqBank), 32'h2);
    wr(12'h900, 32'hFE); rd(12'hA00, rv); chk("R8 both banks", 32'(irqBank), 32'h3);
    wr(12'hA08, 32'h10); rd(12'hA00, rv); chk("R8 bank1 cleared", 32'(irqBank), 32'h1);
    wr(12'h900, 32'hFF); rd(12'hA00, rv); chk("R8 bank0 masked", 32'(irqBank), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule